// File: doc/BRIEF.md
# Load-Store Memory Disambiguation Buffer

This block keeps in-flight loads and stores of an out-of-order core in a small circular buffer, in the order the program issued them. Each operation is given a slot at issue time, before its address is known. When an address later resolves, the buffer checks that slot against its neighbours. A store that resolves looks forward, toward younger entries, for loads that already ran with the same address. A load that resolves looks backward, toward older entries, for stores it must take data from or wait on.

Loads are speculative by default. A load that finds no older store with its address is sent to memory at once. A load that finds a matching older store gets that store's data if the data is present. If the data is not yet present, the load gets the tag of the station that will produce it. When a store exposes a load that ran too early, the buffer asks the pipeline to flush. It cuts the buffer back to that load and trains a small table indexed by PC, so that the pair shares a store-set number. On later visits the load holds back while an older store of its set still has no address.

The core drives the entry index with each address or data event and pops the oldest entry when it retires. The buffer depth must be a power of two.

Top module: `ldst_disamb_buf`

## Requirements
- R1: An accepted allocation (alloc_valid while alloc_ready is high) takes the slot shown on alloc_idx. alloc_idx then advances by one modulo DEPTH. The entry starts with no address, no data and not executed.
- R2: With DEPTH entries in use, alloc_ready is low. An allocation request in that state is dropped and alloc_idx holds its value.
- R3: retire_valid with a non-empty buffer frees the oldest entry. Entries retire strictly from the head, and a freed slot can be reallocated once the tail wraps round to it.
- R4: When a store's address resolves, the buffer looks at younger loads that have already executed with the same address. If any exist, flush_valid pulses high one cycle later with flush_idx set to the oldest of them. The tail moves back to that index, which discards that load and every younger entry.
- R5: A store resolve raises no flush in these cases: the matching loads have not executed, the matching loads are older than the store, or the address differs.
- R6: A load resolve returns kind 0 (forward) when an older store has the same resolved address and its data present. Among several such stores, the youngest older one supplies ld_resp_data.
- R7: When the youngest older matching store has no data yet, the kind is 1 (wait). ld_resp_tag then carries the producer tag given when that store was allocated.
- R8: When no older store has the same resolved address, the kind is 2 (memory), and the load counts as executed. This holds even if older stores still lack addresses, unless R9 applies.
- R9: A load whose store-set number is valid returns kind 3 (hold) when an older store with the same valid number still has no address. The load is not marked executed and may be resolved again later.
- R10: Each flush assigns one store-set number to the PC of the flushed load and to the PC of the store that caused it. Entries allocated afterwards at either PC carry that number.
- R11: Every load resolve gives exactly one ld_resp_valid pulse on the next cycle, echoing the slot in ld_resp_idx. ld_resp_data is zero unless the kind is 0, and ld_resp_tag is zero unless the kind is 1.
- R12: In the cycle where a store resolve triggers a flush, any allocation or retire request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Request to allocate a slot at the tail |
| alloc_is_store | input | 1 | 1 for a store, 0 for a load |
| alloc_pc | input | PC_W | PC of the allocating operation |
| alloc_tag | input | TAG_W | Producer tag of a store's data |
| alloc_ready | output | 1 | Buffer has a free slot |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation takes |
| retire_valid | input | 1 | Free the oldest entry |
| st_addr_valid | input | 1 | A store address resolves |
| st_addr_idx | input | log2(DEPTH) | Slot of that store |
| st_addr | input | ADDR_W | Resolved store address |
| st_data_valid | input | 1 | Store data becomes available |
| st_data_idx | input | log2(DEPTH) | Slot of that store |
| st_data | input | DATA_W | Store data value |
| ld_addr_valid | input | 1 | A load address resolves |
| ld_addr_idx | input | log2(DEPTH) | Slot of that load |
| ld_addr | input | ADDR_W | Resolved load address |
| ld_resp_valid | output | 1 | Load outcome is valid |
| ld_resp_idx | output | log2(DEPTH) | Slot the outcome belongs to |
| ld_resp_kind | output | 2 | 0 forward, 1 wait, 2 memory, 3 hold |
| ld_resp_data | output | DATA_W | Forwarded store data |
| ld_resp_tag | output | TAG_W | Producer tag to wait on |
| flush_valid | output | 1 | Mis-speculated load detected |
| flush_idx | output | log2(DEPTH) | Slot of the oldest offending load |

## Verification
The bench builds the buffer with its default values: eight slots, 16-bit addresses, 32-bit data and a 16-entry store-set table indexed by the low PC bits. With eight slots, a few dozen events are enough to fill the buffer, wrap the pointers past zero, and flush across the wrap point. A flush that moves the tail back below the head index in numeric order is therefore covered. The PCs are chosen so that the trained table entries take part in later allocations, and the hold outcome is reached through a real violation rather than a preset table.

// File: rtl/ldb_pkg.sv
package ldb_pkg;

  // Outcome of a load address resolve
  typedef enum logic [1:0] {
    RESP_FWD  = 2'd0,
    RESP_WAIT = 2'd1,
    RESP_MEM  = 2'd2,
    RESP_HOLD = 2'd3
  } ldb_resp_e;

endpackage

// File: rtl/ldb_ring_ptrs.sv
module ldb_ring_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush_fire,
  input  logic [IDX_W-1:0] flush_to,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush_fire) begin
      // cut the ring back to the offending entry
      tail  <= flush_to;
      count <= {1'b0, IDX_W'(flush_to - head)};
    end else begin
      if (alloc_fire)  tail <= tail + IDX_W'(1);
      if (retire_fire) head <= head + IDX_W'(1);
      count <= count + CNT_W'(alloc_fire) - CNT_W'(retire_fire);
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/ldb_store_set_tbl.sv
module ldb_store_set_tbl #(
  parameter int PC_W    = 12,
  parameter int ENTRIES = 16,
  parameter int SSID_W  = 4,
  localparam int IW = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   rd_pc,
  output logic              rd_valid,
  output logic [SSID_W-1:0] rd_id,
  input  logic              train,
  input  logic [PC_W-1:0]   train_ld_pc,
  input  logic [PC_W-1:0]   train_st_pc
);

  logic              tv  [ENTRIES];
  logic [SSID_W-1:0] tid [ENTRIES];
  logic [SSID_W-1:0] next_id;
  logic [IW-1:0]     ld_i, st_i;
  logic [SSID_W-1:0] join_id;
  logic              fresh;

  assign ld_i     = train_ld_pc[IW-1:0];
  assign st_i     = train_st_pc[IW-1:0];
  assign rd_valid = tv[rd_pc[IW-1:0]];
  assign rd_id    = tid[rd_pc[IW-1:0]];

  // store's set wins, then load's set, else a fresh number
  always_comb begin
    fresh   = 1'b0;
    join_id = next_id;
    if (tv[st_i])      join_id = tid[st_i];
    else if (tv[ld_i]) join_id = tid[ld_i];
    else               fresh   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tv[i] <= 1'b0;
      next_id <= '0;
    end else if (train) begin
      tv[ld_i] <= 1'b1;
      tv[st_i] <= 1'b1;
      if (fresh) next_id <= next_id + SSID_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (train) begin
      tid[ld_i] <= join_id;
      tid[st_i] <= join_id;
    end
  end

endmodule

// File: rtl/ldb_flush_scan.sv
module ldb_flush_scan #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0]  head,
  input  logic [CNT_W-1:0]  count,
  input  logic              probe_valid,
  input  logic [IDX_W-1:0]  probe_idx,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              e_store [DEPTH],
  input  logic              e_ak    [DEPTH],
  input  logic              e_ex    [DEPTH],
  input  logic [ADDR_W-1:0] e_addr  [DEPTH],
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);

  logic [IDX_W-1:0] probe_rel;
  logic [IDX_W-1:0] slot;

  // walk from the head; the first younger executed matching load wins
  always_comb begin
    probe_rel = probe_idx - head;
    hit       = 1'b0;
    hit_idx   = '0;
    slot      = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + IDX_W'(k);
      if (probe_valid && !hit &&
          (CNT_W'(k) < count) && (IDX_W'(k) > probe_rel) &&
          !e_store[slot] && e_ak[slot] && e_ex[slot] &&
          (e_addr[slot] == probe_addr)) begin
        hit     = 1'b1;
        hit_idx = slot;
      end
    end
  end

endmodule

// File: rtl/ldb_fwd_scan.sv
module ldb_fwd_scan
  import ldb_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5,
  parameter int SSID_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  probe_idx,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic              e_store [DEPTH],
  input  logic              e_ak    [DEPTH],
  input  logic [ADDR_W-1:0] e_addr  [DEPTH],
  input  logic              e_dr    [DEPTH],
  input  logic [DATA_W-1:0] e_data  [DEPTH],
  input  logic [TAG_W-1:0]  e_tag   [DEPTH],
  input  logic              e_sv    [DEPTH],
  input  logic [SSID_W-1:0] e_sid   [DEPTH],
  output ldb_resp_e         kind,
  output logic [DATA_W-1:0] data,
  output logic [TAG_W-1:0]  tag
);

  logic [IDX_W-1:0] ld_rel;
  logic [IDX_W-1:0] slot;
  logic [IDX_W-1:0] m_slot;
  logic             match;
  logic             hold;

  // walk oldest to the load; last match seen is the youngest older store
  always_comb begin
    ld_rel = probe_idx - head;
    match  = 1'b0;
    hold   = 1'b0;
    m_slot = '0;
    slot   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      slot = head + IDX_W'(k);
      if ((IDX_W'(k) < ld_rel) && e_store[slot]) begin
        if (e_ak[slot] && (e_addr[slot] == probe_addr)) begin
          match  = 1'b1;
          m_slot = slot;
        end
        if (!e_ak[slot] && e_sv[slot] && e_sv[probe_idx] &&
            (e_sid[slot] == e_sid[probe_idx])) begin
          hold = 1'b1;
        end
      end
    end
  end

  always_comb begin
    kind = RESP_MEM;
    data = '0;
    tag  = '0;
    if (hold) begin
      kind = RESP_HOLD;
    end else if (match) begin
      if (e_dr[m_slot]) begin
        kind = RESP_FWD;
        data = e_data[m_slot];
      end else begin
        kind = RESP_WAIT;
        tag  = e_tag[m_slot];
      end
    end
  end

endmodule

// File: rtl/ldst_disamb_buf.sv
module ldst_disamb_buf
  import ldb_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int TAG_W       = 5,
  parameter int PC_W        = 12,
  parameter int SST_ENTRIES = 16,
  parameter int SSID_W      = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              retire_valid,
  input  logic              st_addr_valid,
  input  logic [IDX_W-1:0]  st_addr_idx,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_data_valid,
  input  logic [IDX_W-1:0]  st_data_idx,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_addr_valid,
  input  logic [IDX_W-1:0]  ld_addr_idx,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_resp_valid,
  output logic [IDX_W-1:0]  ld_resp_idx,
  output logic [1:0]        ld_resp_kind,
  output logic [DATA_W-1:0] ld_resp_data,
  output logic [TAG_W-1:0]  ld_resp_tag,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_idx
);

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  logic             full, empty;
  logic             flush_now;
  logic [IDX_W-1:0] victim_idx;
  logic             alloc_fire, retire_fire;

  // entry storage
  logic              e_store [DEPTH];
  logic [PC_W-1:0]   e_pc    [DEPTH];
  logic [TAG_W-1:0]  e_tag   [DEPTH];
  logic              e_ak    [DEPTH];
  logic [ADDR_W-1:0] e_addr  [DEPTH];
  logic              e_dr    [DEPTH];
  logic [DATA_W-1:0] e_data  [DEPTH];
  logic              e_ex    [DEPTH];
  logic              e_sv    [DEPTH];
  logic [SSID_W-1:0] e_sid   [DEPTH];

  logic              sst_rd_valid;
  logic [SSID_W-1:0] sst_rd_id;
  ldb_resp_e         scan_kind;
  logic [DATA_W-1:0] scan_data;
  logic [TAG_W-1:0]  scan_tag;

  assign alloc_fire  = alloc_valid && !full && !flush_now;
  assign retire_fire = retire_valid && !empty && !flush_now;
  assign alloc_ready = !full;
  assign alloc_idx   = tail_q;

  ldb_ring_ptrs #(.DEPTH(DEPTH)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .alloc_fire (alloc_fire),
    .retire_fire(retire_fire),
    .flush_fire (flush_now),
    .flush_to   (victim_idx),
    .head       (head_q),
    .tail       (tail_q),
    .count      (count_q),
    .full       (full),
    .empty      (empty)
  );

  ldb_store_set_tbl #(
    .PC_W(PC_W), .ENTRIES(SST_ENTRIES), .SSID_W(SSID_W)
  ) u_sst (
    .clk        (clk),
    .rst        (rst),
    .rd_pc      (alloc_pc),
    .rd_valid   (sst_rd_valid),
    .rd_id      (sst_rd_id),
    .train      (flush_now),
    .train_ld_pc(e_pc[victim_idx]),
    .train_st_pc(e_pc[st_addr_idx])
  );

  ldb_flush_scan #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_fscan (
    .head       (head_q),
    .count      (count_q),
    .probe_valid(st_addr_valid),
    .probe_idx  (st_addr_idx),
    .probe_addr (st_addr),
    .e_store    (e_store),
    .e_ak       (e_ak),
    .e_ex       (e_ex),
    .e_addr     (e_addr),
    .hit        (flush_now),
    .hit_idx    (victim_idx)
  );

  ldb_fwd_scan #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TAG_W(TAG_W), .SSID_W(SSID_W)
  ) u_lscan (
    .head      (head_q),
    .probe_idx (ld_addr_idx),
    .probe_addr(ld_addr),
    .e_store   (e_store),
    .e_ak      (e_ak),
    .e_addr    (e_addr),
    .e_dr      (e_dr),
    .e_data    (e_data),
    .e_tag     (e_tag),
    .e_sv      (e_sv),
    .e_sid     (e_sid),
    .kind      (scan_kind),
    .data      (scan_data),
    .tag       (scan_tag)
  );

  // status flags, reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        e_ak[i] <= 1'b0;
        e_dr[i] <= 1'b0;
        e_ex[i] <= 1'b0;
      end
    end else begin
      if (alloc_fire) begin
        e_ak[tail_q] <= 1'b0;
        e_dr[tail_q] <= 1'b0;
        e_ex[tail_q] <= 1'b0;
      end
      if (st_addr_valid) e_ak[st_addr_idx] <= 1'b1;
      if (st_data_valid) e_dr[st_data_idx] <= 1'b1;
      if (ld_addr_valid) begin
        e_ak[ld_addr_idx] <= 1'b1;
        e_ex[ld_addr_idx] <= (scan_kind == RESP_FWD) || (scan_kind == RESP_MEM);
      end
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      e_store[tail_q] <= alloc_is_store;
      e_pc[tail_q]    <= alloc_pc;
      e_tag[tail_q]   <= alloc_tag;
      e_sv[tail_q]    <= sst_rd_valid;
      e_sid[tail_q]   <= sst_rd_id;
    end
    if (st_addr_valid) e_addr[st_addr_idx] <= st_addr;
    if (ld_addr_valid) e_addr[ld_addr_idx] <= ld_addr;
    if (st_data_valid) e_data[st_data_idx] <= st_data;
  end

  // registered outcomes
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_resp_valid <= 1'b0;
      ld_resp_idx   <= '0;
      ld_resp_kind  <= RESP_FWD;
      ld_resp_data  <= '0;
      ld_resp_tag   <= '0;
      flush_valid   <= 1'b0;
      flush_idx     <= '0;
    end else begin
      ld_resp_valid <= ld_addr_valid;
      ld_resp_idx   <= ld_addr_valid ? ld_addr_idx : '0;
      ld_resp_kind  <= ld_addr_valid ? scan_kind : RESP_FWD;
      ld_resp_data  <= ld_addr_valid ? scan_data : '0;
      ld_resp_tag   <= ld_addr_valid ? scan_tag : '0;
      flush_valid   <= flush_now;
      flush_idx     <= flush_now ? victim_idx : '0;
    end
  end

endmodule

// File: rtl/ldb_checker.sv
module ldb_checker #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              alloc_valid,
  input logic              alloc_ready,
  input logic [IDX_W-1:0]  alloc_idx,
  input logic              st_addr_valid,
  input logic              ld_addr_valid,
  input logic              ld_resp_valid,
  input logic [1:0]        ld_resp_kind,
  input logic [DATA_W-1:0] ld_resp_data,
  input logic [TAG_W-1:0]  ld_resp_tag,
  input logic              flush_valid,
  input logic [IDX_W-1:0]  flush_idx,
  input logic              flush_now
);

  p_alloc_step_r1: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && alloc_ready && !flush_now) |=>
      (alloc_idx == IDX_W'($past(alloc_idx) + IDX_W'(1))));

  p_full_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_ready && !flush_now) |=> $stable(alloc_idx));

  p_flush_tail_r4: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> (alloc_idx == flush_idx));

  p_flush_cause_r4: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> $past(st_addr_valid));

  p_resp_follows_r11: assert property (@(posedge clk) disable iff (rst)
    ld_addr_valid |=> ld_resp_valid);

  p_resp_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !ld_addr_valid |=> !ld_resp_valid);

  p_resp_data_clean_r11: assert property (@(posedge clk) disable iff (rst)
    (ld_resp_valid && ld_resp_kind != 2'd0) |-> (ld_resp_data == '0));

  p_resp_tag_clean_r11: assert property (@(posedge clk) disable iff (rst)
    (ld_resp_valid && ld_resp_kind != 2'd1) |-> (ld_resp_tag == '0));

  p_flush_blocks_alloc_r12: assert property (@(posedge clk) disable iff (rst)
    (flush_now && alloc_valid) |=> (alloc_idx == flush_idx));

endmodule

bind ldst_disamb_buf ldb_checker #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
) u_ldb_chk (
  .clk          (clk),
  .rst          (rst),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_idx    (alloc_idx),
  .st_addr_valid(st_addr_valid),
  .ld_addr_valid(ld_addr_valid),
  .ld_resp_valid(ld_resp_valid),
  .ld_resp_kind (ld_resp_kind),
  .ld_resp_data (ld_resp_data),
  .ld_resp_tag  (ld_resp_tag),
  .flush_valid  (flush_valid),
  .flush_idx    (flush_idx),
  .flush_now    (flush_now)
);

// File: tb/ldst_disamb_buf_tb_top.sv
module ldst_disamb_buf_tb_top;

  localparam int D     = 8;
  localparam int IW    = 3;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int TW    = 5;
  localparam int PW    = 12;
  localparam int SSTN  = 16;
  localparam int SIDN  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alloc_valid = 0, alloc_is_store = 0;
  logic [PW-1:0] alloc_pc = '0;
  logic [TW-1:0] alloc_tag = '0;
  logic          alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic          retire_valid = 0;
  logic          st_addr_valid = 0;
  logic [IW-1:0] st_addr_idx = '0;
  logic [AW-1:0] st_addr = '0;
  logic          st_data_valid = 0;
  logic [IW-1:0] st_data_idx = '0;
  logic [DW-1:0] st_data = '0;
  logic          ld_addr_valid = 0;
  logic [IW-1:0] ld_addr_idx = '0;
  logic [AW-1:0] ld_addr = '0;
  logic          ld_resp_valid;
  logic [IW-1:0] ld_resp_idx;
  logic [1:0]    ld_resp_kind;
  logic [DW-1:0] ld_resp_data;
  logic [TW-1:0] ld_resp_tag;
  logic          flush_valid;
  logic [IW-1:0] flush_idx;

  // 8 ns period, 125 MHz
  always #4 clk = ~clk;

  ldst_disamb_buf dut_i (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .alloc_pc(alloc_pc), .alloc_tag(alloc_tag),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .retire_valid(retire_valid),
    .st_addr_valid(st_addr_valid), .st_addr_idx(st_addr_idx), .st_addr(st_addr),
    .st_data_valid(st_data_valid), .st_data_idx(st_data_idx), .st_data(st_data),
    .ld_addr_valid(ld_addr_valid), .ld_addr_idx(ld_addr_idx), .ld_addr(ld_addr),
    .ld_resp_valid(ld_resp_valid), .ld_resp_idx(ld_resp_idx),
    .ld_resp_kind(ld_resp_kind), .ld_resp_data(ld_resp_data),
    .ld_resp_tag(ld_resp_tag),
    .flush_valid(flush_valid), .flush_idx(flush_idx)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // behavioural reference model
  typedef struct {
    bit st; int pc; int tag; bit ak; int addr;
    bit dr; logic [31:0] data; bit ex; bit sv; int sid;
  } ment_t;
  ment_t mq[$];
  int    mhead = 0;
  bit    msv [SSTN];
  int    msid[SSTN];
  int    mnext = 0;

  function automatic int rel_of(int idx);
    return (idx - mhead + D) % D;
  endfunction

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(string req);
    bit          e_lv = 0, e_fv = 0;
    int          e_kind = 0, e_tag = 0, e_li = 0, e_fi = 0, vj = -1;
    logic [31:0] e_data = '0;
    bool_blk: begin end
    // store resolve: oldest younger executed matching load
    if (st_addr_valid) begin
      int k = rel_of(int'(st_addr_idx));
      for (int j = k + 1; j < mq.size(); j++)
        if (vj < 0 && !mq[j].st && mq[j].ak && mq[j].ex && mq[j].addr == int'(st_addr))
          vj = j;
      if (vj >= 0) begin
        e_fv = 1;
        e_fi = (mhead + vj) % D;
      end
    end
    // load resolve: hold check and youngest older matching store
    if (ld_addr_valid) begin
      int k = rel_of(int'(ld_addr_idx));
      bit hold = 0, match = 0;
      int m = 0;
      for (int i = 0; i < k; i++) begin
        if (mq[i].st && mq[i].ak && mq[i].addr == int'(ld_addr)) begin
          match = 1; m = i;
        end
        if (mq[i].st && !mq[i].ak && mq[i].sv && mq[k].sv && mq[i].sid == mq[k].sid)
          hold = 1;
      end
      e_lv = 1;
      e_li = int'(ld_addr_idx);
      if (hold) e_kind = 3;
      else if (match && mq[m].dr) begin e_kind = 0; e_data = mq[m].data; end
      else if (match) begin e_kind = 1; e_tag = mq[m].tag; end
      else e_kind = 2;
      mq[k].ak = 1;
      mq[k].addr = int'(ld_addr);
      mq[k].ex = (e_kind == 0 || e_kind == 2);
    end
    if (st_data_valid) begin
      int k = rel_of(int'(st_data_idx));
      mq[k].dr = 1;
      mq[k].data = st_data;
    end
    if (st_addr_valid) begin
      int k = rel_of(int'(st_addr_idx));
      mq[k].ak = 1;
      mq[k].addr = int'(st_addr);
      if (e_fv) begin
        int li = mq[vj].pc % SSTN;
        int si = mq[k].pc % SSTN;
        int id;
        if (msv[si]) id = msid[si];
        else if (msv[li]) id = msid[li];
        else begin id = mnext; mnext = (mnext + 1) % SIDN; end
        msv[li] = 1; msv[si] = 1; msid[li] = id; msid[si] = id;
        while (mq.size() > vj) mq.delete(mq.size() - 1);
      end
    end
    if (!e_fv) begin
      bit room = (mq.size() < D);
      if (retire_valid && mq.size() > 0) begin
        mq.delete(0);
        mhead = (mhead + 1) % D;
      end
      if (alloc_valid && room) begin
        ment_t n;
        int ix = int'(alloc_pc) % SSTN;
        n.st = alloc_is_store; n.pc = int'(alloc_pc); n.tag = int'(alloc_tag);
        n.ak = 0; n.addr = 0; n.dr = 0; n.data = '0; n.ex = 0;
        n.sv = msv[ix]; n.sid = msid[ix];
        mq.push_back(n);
      end
    end
    @(posedge clk);
    #2;
    checks++;
    if (ld_resp_valid !== e_lv || int'(ld_resp_idx) != e_li || int'(ld_resp_kind) != e_kind ||
        ld_resp_data !== e_data || int'(ld_resp_tag) != e_tag) begin
      errors++;
      $display("FAIL %s load outcome: got v%0d i%0d k%0d d%h t%0d expected v%0d i%0d k%0d d%h t%0d",
               req, ld_resp_valid, ld_resp_idx, ld_resp_kind, ld_resp_data, ld_resp_tag,
               e_lv, e_li, e_kind, e_data, e_tag);
    end
    checks++;
    if (flush_valid !== e_fv || int'(flush_idx) != e_fi) begin
      errors++;
      $display("FAIL %s flush: got v%0d i%0d expected v%0d i%0d",
               req, flush_valid, flush_idx, e_fv, e_fi);
    end
    checks++;
    if (alloc_ready !== (mq.size() < D) || int'(alloc_idx) != (mhead + mq.size()) % D) begin
      errors++;
      $display("FAIL %s ring: got ready%0d idx%0d expected ready%0d idx%0d",
               req, alloc_ready, alloc_idx, (mq.size() < D), (mhead + mq.size()) % D);
    end
    alloc_valid = 0; retire_valid = 0;
    st_addr_valid = 0; st_data_valid = 0; ld_addr_valid = 0;
  endtask

  task automatic do_alloc(bit st, int pc, int tg, string req);
    alloc_valid = 1; alloc_is_store = st;
    alloc_pc = PW'(pc); alloc_tag = TW'(tg);
    tick(req);
  endtask

  task automatic do_sa(int idx, int a, string req);
    st_addr_valid = 1; st_addr_idx = IW'(idx); st_addr = AW'(a);
    tick(req);
  endtask

  task automatic do_sd(int idx, int d, string req);
    st_data_valid = 1; st_data_idx = IW'(idx); st_data = DW'(d);
    tick(req);
  endtask

  task automatic do_la(int idx, int a, string req);
    ld_addr_valid = 1; ld_addr_idx = IW'(idx); ld_addr = AW'(a);
    tick(req);
  endtask

  task automatic do_rt(string req);
    retire_valid = 1;
    tick(req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    for (int i = 0; i < SSTN; i++) begin msv[i] = 0; msid[i] = 0; end
    repeat (3) @(posedge clk);
    #2 rst = 0;
    // reset state
    check_eq("R1", "reset alloc_ready", int'(alloc_ready), 1);
    check_eq("R1", "reset alloc_idx", int'(alloc_idx), 0);
    check_eq("R11", "reset ld_resp_valid", int'(ld_resp_valid), 0);
    check_eq("R4", "reset flush_valid", int'(flush_valid), 0);

    // A: speculative load then violating store
    do_alloc(1, 'h010, 3, "R1");
    check_eq("R1", "alloc_idx after first", int'(alloc_idx), 1);
    do_alloc(0, 'h021, 0, "R1");
    do_la(1, 'h40, "R8");
    check_eq("R8", "kind with unresolved older store", int'(ld_resp_kind), 2);
    do_sa(0, 'h40, "R4");
    check_eq("R4", "flush_valid", int'(flush_valid), 1);
    check_eq("R4", "flush_idx", int'(flush_idx), 1);
    check_eq("R4", "tail moved back", int'(alloc_idx), 1);
    do_rt("R3");
    check_eq("R3", "empty after retire", int'(alloc_ready), 1);

    // B: trained store set makes the load hold, then wait, then forward
    do_alloc(1, 'h010, 7, "R10");
    do_alloc(0, 'h021, 0, "R10");
    do_la(2, 'h80, "R9");
    check_eq("R9", "hold on same-set store", int'(ld_resp_kind), 3);
    check_eq("R10", "trained pair holds", int'(ld_resp_valid), 1);
    do_sa(1, 'h80, "R5");
    check_eq("R5", "no flush for unexecuted load", int'(flush_valid), 0);
    do_la(2, 'h80, "R7");
    check_eq("R7", "wait kind", int'(ld_resp_kind), 1);
    check_eq("R7", "producer tag", int'(ld_resp_tag), 7);
    check_eq("R11", "data zero on wait", int'(ld_resp_data), 0);
    do_sd(1, 'hCAFE, "R6");
    do_la(2, 'h80, "R6");
    check_eq("R6", "forward kind", int'(ld_resp_kind), 0);
    check_eq("R6", "forward data", int'(ld_resp_data), 'hCAFE);
    check_eq("R11", "resp idx", int'(ld_resp_idx), 2);
    do_rt("R3");
    do_rt("R3");

    // C: youngest older store, fill, wrap, multi-load flush
    do_alloc(1, 'h0A4, 1, "R1");
    do_alloc(1, 'h0A5, 2, "R1");
    do_alloc(0, 'h0A6, 0, "R1");
    do_alloc(1, 'h0A7, 3, "R1");
    do_sd(3, 'h11, "R6");
    do_sa(3, 'h100, "R6");
    do_sd(4, 'h22, "R6");
    do_sa(4, 'h100, "R6");
    do_sa(6, 'h100, "R5");
    do_sd(6, 'h33, "R6");
    do_la(5, 'h100, "R6");
    check_eq("R6", "youngest older store data", int'(ld_resp_data), 'h22);
    do_alloc(0, 'h0A8, 0, "R1");
    do_alloc(1, 'h0A9, 4, "R1");
    do_alloc(0, 'h0AA, 0, "R1");
    do_alloc(0, 'h0AB, 0, "R2");
    check_eq("R2", "full drops ready", int'(alloc_ready), 0);
    do_alloc(1, 'h0B0, 5, "R2");
    check_eq("R2", "full keeps idx", int'(alloc_idx), 3);
    do_la(7, 'h200, "R8");
    check_eq("R8", "no match goes to memory", int'(ld_resp_kind), 2);
    do_la(1, 'h200, "R8");
    do_la(2, 'h200, "R8");
    alloc_valid = 1; alloc_is_store = 0; alloc_pc = PW'('h0B1);
    retire_valid = 1;
    do_sa(0, 'h200, "R12");
    check_eq("R4", "oldest younger load flushed", int'(flush_idx), 1);
    check_eq("R5", "older load kept", int'(flush_valid), 1);
    check_eq("R12", "alloc ignored on flush", int'(alloc_idx), 1);
    for (int i = 0; i < 6; i++) do_rt("R3");
    check_eq("R3", "drained", int'(alloc_ready), 1);
    do_rt("R3");
    check_eq("R3", "retire on empty", int'(alloc_idx), 1);
    do_alloc(1, 'h0A9, 6, "R10");
    do_alloc(0, 'h0AA, 0, "R10");
    do_la(2, 'h300, "R10");
    check_eq("R10", "retrained pair holds", int'(ld_resp_kind), 3);

    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule